// File: doc/BRIEF.md
# Hierarchical Policy-Based Task Selector

This block picks the next task to run from a small scheduling tree that is fixed at build time. Each leaf is a task slot. A slot holds a valid flag, a priority and a 16-bit handle. The handle points to the task's descriptor in shared memory; the block never stores the descriptor itself. Slots are grouped under intermediate scheduling nodes. The root scheduling node sees two kinds of children: the winners of those groups, and a few slots attached to it directly.

Each scheduling node applies its own policy to its direct children. The policies are earliest arrival, highest priority, and round-robin fair sharing. A group winner enters its parent as one candidate and carries its own priority and arrival time.

A consumer raises a request and sees the winning slot index, its handle and a valid flag. It raises acknowledge to take that task. Taking a task frees the slot and advances the round-robin pointers along the winning path. Software-side agents register and remove tasks through one write port. In the default build there are two groups of three slots and two slots attached directly to the root.

Top module: `task_selector`

## Requirements
- R1: After reset every slot is empty and every round-robin pointer is 0. `empty_o` is 1, and `win_vld_o` is 0 even while `req_i` is 1.
- R2: A write with `wr_en_i`=1 and `wr_add_i`=1 makes slot `wr_slot_i` valid. It stores `wr_prio_i` and `wr_ref_i` and gives the slot a new arrival time, later than all earlier registrations, even if the slot was already valid. A write with `wr_add_i`=0 makes the slot invalid. Removing an empty slot changes nothing.
- R3: `empty_o` is 1 exactly when no slot is valid. `win_vld_o` equals `req_i` AND NOT `empty_o`. When `win_vld_o` is 1, `win_idx_o` is the winning slot and `win_ref_o` is that slot's stored handle.
- R4: Group g covers slots 3g, 3g+1 and 3g+2. The root's children, in child order, are: the group-0 winner, the group-1 winner, slot 6 and slot 7. A group winner competes at the root with its own priority and arrival time.
- R5: Policy code 0 picks the valid child with the earliest arrival. Code 3 behaves the same way. The order is exact while all live tasks were registered within 2^(TS_W-1) registrations of each other.
- R6: Policy code 1 picks the valid child with the largest priority value. On a tie it picks the lower child index, which is also the lower slot number.
- R7: Policy code 2 picks the first valid child at or after the node's pointer, counting cyclically in child order.
- R8: A selection is taken when `req_i`, `ack_i` and `win_vld_o` are all 1 at a rising clock edge. The taken slot becomes invalid. The root pointer becomes the winning root child index plus 1, wrapping to 0. If the winner came from group g, that group's pointer becomes its winning child index plus 1, wrapping to 0. All other pointers keep their values. Pointers move on every taken selection, whatever the policies are.
- R9: If a registration targets the slot being taken in the same cycle, the registration wins: the slot stays valid with the new contents.
- R10: `ack_i` has no effect while `req_i` is 0 or the tree is empty. With no write and no taken selection, the winner stays the same from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pol_grp_i | input | 2*N_GRP | Policy code of each intermediate node, 2 bits per node |
| pol_root_i | input | 2 | Policy code of the root node |
| wr_en_i | input | 1 | Write strobe |
| wr_add_i | input | 1 | 1 registers a task, 0 removes one |
| wr_slot_i | input | IDX_W | Target slot |
| wr_prio_i | input | PRIO_W | Priority of the task being registered |
| wr_ref_i | input | REF_W | Descriptor handle of the task being registered |
| req_i | input | 1 | Selection request |
| ack_i | input | 1 | Take the offered winner |
| win_vld_o | output | 1 | A winner is being offered |
| win_idx_o | output | IDX_W | Winning slot index |
| win_ref_o | output | REF_W | Handle stored in the winning slot |
| empty_o | output | 1 | No slot holds a task |

## Verification
The assertions check the handshake rules on every cycle. No offer is made while the tree is empty or without a request. A registration always leaves the tree non-empty. A taken winner is not offered again in the next cycle. The offer holds steady while nothing changes. Only the bench's scenarios can show that each policy picks the right child at every level, and they do this for every combination of node policies. The same holds for priority tie-breaks, arrival order across group boundaries, round-robin pointers carried from one scenario to the next, and a write colliding with a take.

// File: rtl/task_sel_pkg.sv
package task_sel_pkg;
  typedef enum logic [1:0] {
    POL_FIFO = 2'd0,
    POL_PRIO = 2'd1,
    POL_FAIR = 2'd2,
    POL_ALT  = 2'd3
  } pol_e;
endpackage

// File: rtl/task_slots.sv
module task_slots #(
  parameter int N_SLOTS = 8,
  parameter int PRIO_W  = 4,
  parameter int REF_W   = 16,
  parameter int TS_W    = 8,
  localparam int IDX_W  = $clog2(N_SLOTS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic                             wr_add_i,
  input  logic [IDX_W-1:0]                 wr_slot_i,
  input  logic [PRIO_W-1:0]                wr_prio_i,
  input  logic [REF_W-1:0]                 wr_ref_i,
  input  logic                             pop_i,
  input  logic [IDX_W-1:0]                 pop_slot_i,
  output logic [N_SLOTS-1:0]               vld_o,
  output logic [N_SLOTS-1:0][PRIO_W-1:0]   prio_o,
  output logic [N_SLOTS-1:0][REF_W-1:0]    ref_o,
  output logic [N_SLOTS-1:0][TS_W-1:0]     ts_o
);
  logic [TS_W-1:0] stamp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= '0;
      prio_o  <= '0;
      ref_o   <= '0;
      ts_o    <= '0;
      stamp_q <= '0;
    end else begin
      if (pop_i) vld_o[pop_slot_i] <= 1'b0;
      // write issued after pop so a colliding registration survives
      if (wr_en_i) begin
        if (wr_add_i) begin
          vld_o[wr_slot_i]  <= 1'b1;
          prio_o[wr_slot_i] <= wr_prio_i;
          ref_o[wr_slot_i]  <= wr_ref_i;
          ts_o[wr_slot_i]   <= stamp_q;
          stamp_q           <= stamp_q + 1'b1;
        end else begin
          vld_o[wr_slot_i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sched_node.sv
module sched_node import task_sel_pkg::*; #(
  parameter int N_CH   = 3,
  parameter int PRIO_W = 4,
  parameter int TS_W   = 8,
  parameter int IDX_W  = 3,
  localparam int PTR_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [N_CH-1:0]             ch_vld_i,
  input  logic [N_CH-1:0][PRIO_W-1:0] ch_prio_i,
  input  logic [N_CH-1:0][TS_W-1:0]   ch_ts_i,
  input  logic [N_CH-1:0][IDX_W-1:0]  ch_leaf_i,
  input  logic [1:0]                  pol_i,
  input  logic [PTR_W-1:0]            ptr_i,
  output logic                        win_vld_o,
  output logic [PTR_W-1:0]            win_ch_o,
  output logic [IDX_W-1:0]            win_leaf_o
);
  // wrap-aware age compare: a arrived before b
  function automatic logic older(input logic [TS_W-1:0] a, input logic [TS_W-1:0] b);
    logic [TS_W-1:0] d;
    d = a - b;
    return d[TS_W-1];
  endfunction

  logic [PTR_W-1:0]  sel;
  logic              found;
  logic [PRIO_W-1:0] best_prio;
  logic [TS_W-1:0]   best_ts;

  always_comb begin
    sel       = '0;
    found     = 1'b0;
    best_prio = '0;
    best_ts   = '0;
    case (pol_e'(pol_i))
      POL_PRIO: begin
        for (int i = 0; i < N_CH; i++) begin
          if (ch_vld_i[i] && (!found || ch_prio_i[i] > best_prio)) begin
            sel       = PTR_W'(i);
            found     = 1'b1;
            best_prio = ch_prio_i[i];
          end
        end
      end
      POL_FAIR: begin
        for (int k = 0; k < N_CH; k++) begin
          int idx;
          idx = int'(ptr_i) + k;
          if (idx >= N_CH) idx = idx - N_CH;
          if (!found && ch_vld_i[idx]) begin
            sel   = PTR_W'(idx);
            found = 1'b1;
          end
        end
      end
      default: begin
        for (int i = 0; i < N_CH; i++) begin
          if (ch_vld_i[i] && (!found || older(ch_ts_i[i], best_ts))) begin
            sel     = PTR_W'(i);
            found   = 1'b1;
            best_ts = ch_ts_i[i];
          end
        end
      end
    endcase
  end

  assign win_vld_o  = |ch_vld_i;
  assign win_ch_o   = sel;
  assign win_leaf_o = ch_leaf_i[sel];
endmodule

// File: rtl/task_selector.sv
module task_selector import task_sel_pkg::*; #(
  parameter int N_GRP    = 2,
  parameter int GRP_SZ   = 3,
  parameter int N_DIRECT = 2,
  parameter int PRIO_W   = 4,
  parameter int REF_W    = 16,
  parameter int TS_W     = 8,
  localparam int N_SLOTS = N_GRP * GRP_SZ + N_DIRECT,
  localparam int IDX_W   = $clog2(N_SLOTS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_GRP-1:0][1:0] pol_grp_i,
  input  logic [1:0]            pol_root_i,
  input  logic                  wr_en_i,
  input  logic                  wr_add_i,
  input  logic [IDX_W-1:0]      wr_slot_i,
  input  logic [PRIO_W-1:0]     wr_prio_i,
  input  logic [REF_W-1:0]      wr_ref_i,
  input  logic                  req_i,
  input  logic                  ack_i,
  output logic                  win_vld_o,
  output logic [IDX_W-1:0]      win_idx_o,
  output logic [REF_W-1:0]      win_ref_o,
  output logic                  empty_o
);
  localparam int N_ROOT = N_GRP + N_DIRECT;
  localparam int GP_W   = (GRP_SZ > 1) ? $clog2(GRP_SZ) : 1;
  localparam int RP_W   = (N_ROOT > 1) ? $clog2(N_ROOT) : 1;

  logic [N_SLOTS-1:0]             s_vld;
  logic [N_SLOTS-1:0][PRIO_W-1:0] s_prio;
  logic [N_SLOTS-1:0][REF_W-1:0]  s_ref;
  logic [N_SLOTS-1:0][TS_W-1:0]   s_ts;

  logic [N_GRP-1:0]             g_vld;
  logic [N_GRP-1:0][GP_W-1:0]   g_ch;
  logic [N_GRP-1:0][IDX_W-1:0]  g_leaf;
  logic [N_GRP-1:0][GP_W-1:0]   ptr_g_q;

  logic [N_ROOT-1:0]             r_vld;
  logic [N_ROOT-1:0][PRIO_W-1:0] r_prio;
  logic [N_ROOT-1:0][TS_W-1:0]   r_ts;
  logic [N_ROOT-1:0][IDX_W-1:0]  r_leaf;
  logic                          root_vld;
  logic [RP_W-1:0]               root_ch;
  logic [IDX_W-1:0]              root_leaf;
  logic [RP_W-1:0]               ptr_r_q;
  logic                          take;

  assign take = req_i & ack_i & root_vld;

  task_slots #(
    .N_SLOTS(N_SLOTS), .PRIO_W(PRIO_W), .REF_W(REF_W), .TS_W(TS_W)
  ) u_slots (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_add_i   (wr_add_i),
    .wr_slot_i  (wr_slot_i),
    .wr_prio_i  (wr_prio_i),
    .wr_ref_i   (wr_ref_i),
    .pop_i      (take),
    .pop_slot_i (root_leaf),
    .vld_o      (s_vld),
    .prio_o     (s_prio),
    .ref_o      (s_ref),
    .ts_o       (s_ts)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : gen_grp
    logic [GRP_SZ-1:0][IDX_W-1:0] leaf_ids;
    for (genvar j = 0; j < GRP_SZ; j++) begin : gen_id
      assign leaf_ids[j] = IDX_W'(g * GRP_SZ + j);
    end

    sched_node #(
      .N_CH(GRP_SZ), .PRIO_W(PRIO_W), .TS_W(TS_W), .IDX_W(IDX_W)
    ) u_node (
      .ch_vld_i   (s_vld[g*GRP_SZ +: GRP_SZ]),
      .ch_prio_i  (s_prio[g*GRP_SZ +: GRP_SZ]),
      .ch_ts_i    (s_ts[g*GRP_SZ +: GRP_SZ]),
      .ch_leaf_i  (leaf_ids),
      .pol_i      (pol_grp_i[g]),
      .ptr_i      (ptr_g_q[g]),
      .win_vld_o  (g_vld[g]),
      .win_ch_o   (g_ch[g]),
      .win_leaf_o (g_leaf[g])
    );

    // group winner enters the root with its own attributes
    assign r_vld[g]  = g_vld[g];
    assign r_prio[g] = s_prio[g_leaf[g]];
    assign r_ts[g]   = s_ts[g_leaf[g]];
    assign r_leaf[g] = g_leaf[g];
  end

  for (genvar d = 0; d < N_DIRECT; d++) begin : gen_direct
    assign r_vld[N_GRP+d]  = s_vld[N_GRP*GRP_SZ+d];
    assign r_prio[N_GRP+d] = s_prio[N_GRP*GRP_SZ+d];
    assign r_ts[N_GRP+d]   = s_ts[N_GRP*GRP_SZ+d];
    assign r_leaf[N_GRP+d] = IDX_W'(N_GRP*GRP_SZ+d);
  end

  sched_node #(
    .N_CH(N_ROOT), .PRIO_W(PRIO_W), .TS_W(TS_W), .IDX_W(IDX_W)
  ) u_root (
    .ch_vld_i   (r_vld),
    .ch_prio_i  (r_prio),
    .ch_ts_i    (r_ts),
    .ch_leaf_i  (r_leaf),
    .pol_i      (pol_root_i),
    .ptr_i      (ptr_r_q),
    .win_vld_o  (root_vld),
    .win_ch_o   (root_ch),
    .win_leaf_o (root_leaf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_r_q <= '0;
      ptr_g_q <= '0;
    end else if (take) begin
      ptr_r_q <= (root_ch == RP_W'(N_ROOT-1)) ? '0 : root_ch + 1'b1;
      for (int g = 0; g < N_GRP; g++) begin
        if (root_ch == RP_W'(g))
          ptr_g_q[g] <= (g_ch[g] == GP_W'(GRP_SZ-1)) ? '0 : g_ch[g] + 1'b1;
      end
    end
  end

  assign win_vld_o = req_i & root_vld;
  assign win_idx_o = root_leaf;
  assign win_ref_o = s_ref[root_leaf];
  assign empty_o   = ~root_vld;
endmodule

// File: rtl/task_selector_chk.sv
module task_selector_chk #(
  parameter int N_GRP = 2,
  parameter int IDX_W = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [N_GRP-1:0][1:0] pol_grp_i,
  input logic [1:0]            pol_root_i,
  input logic                  wr_en_i,
  input logic                  wr_add_i,
  input logic                  req_i,
  input logic                  ack_i,
  input logic                  win_vld_o,
  input logic [IDX_W-1:0]      win_idx_o,
  input logic                  empty_o
);
  assert_empty_no_offer_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !win_vld_o);

  assert_offer_needs_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld_o |-> req_i);

  assert_add_fills_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_add_i) |=> !empty_o);

  assert_take_consumes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ack_i && win_vld_o && !wr_en_i) |=> (!win_vld_o || win_idx_o != $past(win_idx_o)));

  assert_idle_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && $past(req_i) && !$past(wr_en_i) && !$past(ack_i) &&
     $stable(pol_grp_i) && $stable(pol_root_i)) |-> ($stable(win_idx_o) && $stable(win_vld_o)));
endmodule

bind task_selector task_selector_chk #(.N_GRP(N_GRP), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pol_grp_i  (pol_grp_i),
  .pol_root_i (pol_root_i),
  .wr_en_i    (wr_en_i),
  .wr_add_i   (wr_add_i),
  .req_i      (req_i),
  .ack_i      (ack_i),
  .win_vld_o  (win_vld_o),
  .win_idx_o  (win_idx_o),
  .empty_o    (empty_o)
);

// File: tb/task_selector_test.sv
module task_selector_test;
  localparam int N_GRP = 2;
  localparam int N_SL  = 8;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [N_GRP-1:0][1:0] pol_grp_i = '0;
  logic [1:0]            pol_root_i = '0;
  logic                  wr_en_i = 1'b0;
  logic                  wr_add_i = 1'b0;
  logic [2:0]            wr_slot_i = '0;
  logic [3:0]            wr_prio_i = '0;
  logic [15:0]           wr_ref_i = '0;
  logic                  req_i = 1'b0;
  logic                  ack_i = 1'b0;
  logic                  win_vld_o;
  logic [2:0]            win_idx_o;
  logic [15:0]           win_ref_o;
  logic                  empty_o;

  task_selector uut (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model
  int mvld [N_SL];
  int mprio[N_SL];
  int mref [N_SL];
  int mseq [N_SL];
  int seqc = 0;
  int mptr_g[N_GRP];
  int mptr_r = 0;
  int e_leaf, e_rc;
  int e_gc[N_GRP];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int pick(input int pol, input int n, input int cand[4], input int ptr);
    int best;
    best = -1;
    if (pol == 2) begin
      for (int k = 0; k < n; k++) begin
        int c;
        c = (ptr + k) % n;
        if (best < 0 && cand[c] >= 0) best = c;
      end
    end else begin
      for (int i = 0; i < n; i++) begin
        if (cand[i] >= 0) begin
          if (best < 0) best = i;
          else if (pol == 1 && mprio[cand[i]] > mprio[cand[best]]) best = i;
          else if (pol != 1 && mseq[cand[i]] < mseq[cand[best]]) best = i;
        end
      end
    end
    return best;
  endfunction

  // R4: group g owns slots 3g..3g+2, root children are g0, g1, slot 6, slot 7
  function automatic void eval();
    int cand[4];
    int gl[N_GRP];
    for (int g = 0; g < N_GRP; g++) begin
      for (int j = 0; j < 4; j++) cand[j] = -1;
      for (int j = 0; j < 3; j++) cand[j] = (mvld[g*3+j] != 0) ? g*3+j : -1;
      e_gc[g] = pick(int'(pol_grp_i[g]), 3, cand, mptr_g[g]);
      gl[g] = (e_gc[g] >= 0) ? cand[e_gc[g]] : -1;
    end
    cand[0] = gl[0];
    cand[1] = gl[1];
    cand[2] = (mvld[6] != 0) ? 6 : -1;
    cand[3] = (mvld[7] != 0) ? 7 : -1;
    e_rc = pick(int'(pol_root_i), 4, cand, mptr_r);
    e_leaf = (e_rc >= 0) ? cand[e_rc] : -1;
  endfunction

  task automatic step(input bit wen, input bit add, input int slot, input int prio,
                      input int rf, input bit rq, input bit ak, input string tag);
    bit tk;
    @(negedge clk_i);
    wr_en_i = wen; wr_add_i = add; wr_slot_i = 3'(slot);
    wr_prio_i = 4'(prio); wr_ref_i = 16'(rf);
    req_i = rq; ack_i = ak;
    #1;
    eval();
    chk(empty_o == (e_leaf < 0), "R3", "empty", int'(empty_o), int'(e_leaf < 0));
    chk(win_vld_o == (rq && e_leaf >= 0), tag, "win_vld", int'(win_vld_o), int'(rq && e_leaf >= 0));
    if (rq && e_leaf >= 0) begin
      chk(int'(win_idx_o) == e_leaf, tag, "win_idx", int'(win_idx_o), e_leaf);
      chk(int'(win_ref_o) == mref[e_leaf], tag, "win_ref", int'(win_ref_o), mref[e_leaf]);
    end
    tk = rq && ak && (e_leaf >= 0);
    @(posedge clk_i);
    // R8: take then R9: write overrides
    if (tk) begin
      mvld[e_leaf] = 0;
      if (e_rc < N_GRP) mptr_g[e_rc] = (e_gc[e_rc] + 1) % 3;
      mptr_r = (e_rc + 1) % 4;
    end
    if (wen) begin
      if (add) begin
        mvld[slot] = 1; mprio[slot] = prio; mref[slot] = rf; mseq[slot] = seqc; seqc++;
      end else mvld[slot] = 0;
    end
  endtask

  function automatic string ptag(input int p);
    case (p)
      1: return "R6";
      2: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic sweep(input int c, input int pg0, input int pg1, input int pr);
    pol_grp_i[0] = 2'(pg0); pol_grp_i[1] = 2'(pg1); pol_root_i = 2'(pr);
    for (int i = 0; i < N_SL; i++) begin
      int s;
      s = (i * 3 + c) % N_SL;
      step(1, 1, s, (s * 5 + c) % 4, 16'h1000 + c * 16 + s, 0, 0, "R2");
    end
    for (int i = 0; i < N_SL; i++) step(0, 0, 0, 0, 0, 1, 1, ptag(pr));
    step(0, 0, 0, 0, 0, 1, 0, "R3");
  endtask

  initial begin
    for (int i = 0; i < N_SL; i++) begin mvld[i] = 0; mprio[i] = 0; mref[i] = 0; mseq[i] = 0; end
    for (int g = 0; g < N_GRP; g++) mptr_g[g] = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    req_i = 1'b1;
    #1;
    chk(empty_o == 1'b1, "R1", "empty after reset", int'(empty_o), 1);
    chk(win_vld_o == 1'b0, "R1", "win_vld after reset", int'(win_vld_o), 0);
    // R2: removal of empty slot has no effect
    step(1, 0, 3, 0, 0, 1, 0, "R2");
    step(0, 0, 0, 0, 0, 1, 1, "R10");
    // all 27 policy combinations, then the alternate FIFO code
    for (int c = 0; c < 27; c++) sweep(c, c % 3, (c / 3) % 3, c / 9);
    sweep(27, 3, 3, 3);
    sweep(28, 3, 1, 3);
    // R9: registration colliding with the take of the same slot
    pol_grp_i = '0; pol_root_i = 2'd0;
    step(1, 1, 0, 2, 16'hA000, 0, 0, "R2");
    step(1, 1, 4, 3, 16'hA004, 0, 0, "R2");
    step(1, 1, 0, 5, 16'hA0F0, 1, 1, "R9");
    step(0, 0, 0, 0, 0, 1, 0, "R9");
    // R10: ack without request leaves winner in place
    step(0, 0, 0, 0, 0, 0, 1, "R10");
    step(0, 0, 0, 0, 0, 1, 0, "R10");
    // R2: rewrite of a valid slot renews its arrival
    step(1, 1, 4, 3, 16'hA044, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 1, 0, "R5");
    step(1, 0, 0, 0, 0, 1, 0, "R2");
    step(0, 0, 0, 0, 0, 1, 1, "R8");
    step(0, 0, 0, 0, 0, 1, 0, "R3");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule